// File: doc/BRIEF.md
# Slice Ganging Controller

This block steers a row of narrow SIMD slices, each four lanes wide, that together stand in for one wide warp datapath (eight slices give 32 lanes). Out of reset every slice belongs to a single gang, so the shared front end fetches and decodes one instruction stream for all of them. Whenever the slices report a fresh set of next-PC values on the update strobe, the controller regroups them. Slices of one gang that still agree on a PC stay together as a smaller gang. A slice left alone on its PC is handed over to its own front end and runs independently.

Two controls select the regrouping policy. With the elastic select low, a gang that has been split is never rebuilt, and an independent slice stays independent. With it high, the controller looks across the whole row on every strobe and joins any valid slices that share a PC into one gang, whatever their previous grouping. A separate enable also splits slices of a gang that took different memory paths, using a per-slice miss bit supplied with the PCs. Each gang is named by the index of its lowest-numbered member. On the cycle after a strobe, the controller raises one fetch request for each gang of two or more slices, at that gang's leader.

Top module: `sg_gang_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, every slice reads as ganged (flag 1) with gang ID 0, and every fetch request is 0.
- R2: On a clock edge with the update strobe low, no gang ID and no ganged flag changes, and every fetch request reads 0 on the next cycle.
- R3: On a strobe edge, the valid slices that may join (see R5, R6, R7) and that report equal PCs form one gang. From the next cycle, each member's gang ID is the lowest slice index in that gang.
- R4: A slice that is invalid at a strobe, or that finds no slice it may join, becomes independent from the next cycle: its ganged flag is 0 and its gang ID equals its own index.
- R5: With elastic_mode_i = 0, slices may join only if both were ganged with the same gang ID before the strobe. An independent slice stays independent, and separate gangs never merge, even on equal PCs.
- R6: With elastic_mode_i = 1, any two valid slices with equal PCs may join, whatever their earlier gang or flag, so split gangs and independent slices merge again.
- R7: With mem_split_en_i = 1, two slices may join only if their miss bits are also equal. With mem_split_en_i = 0, the miss bits have no effect.
- R8: On the cycle after a strobe edge, fetch_req_o[k] is 1 exactly when slice k leads a gang of at least two slices. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_upd_i | input | 1 | Strobe: the slice PCs, valid and miss bits are to be evaluated |
| slice_pc_i | input | NUM_SLICES*PC_W | Next PC of each slice; slice i in bits [i*PC_W +: PC_W] |
| slice_vld_i | input | NUM_SLICES | Slice i has live threads |
| slice_miss_i | input | NUM_SLICES | Slice i's last memory access missed the first-level cache |
| elastic_mode_i | input | 1 | 0 = gangs never reform, 1 = gangs merge on equal PCs |
| mem_split_en_i | input | 1 | 1 = split slices whose miss bits differ |
| gang_id_o | output | NUM_SLICES*ID_W | Gang ID of slice i in bits [i*ID_W +: ID_W] |
| ganged_o | output | NUM_SLICES | 1 = slice driven by the ganging unit, 0 = independent |
| fetch_req_o | output | NUM_SLICES | One fetch request per gang, at the leader's index, for one cycle |

## Verification
The bench goes after the following corner cases:
- Two gangs that come to share a PC in inelastic mode. A design that compared PCs across the whole row would merge them.
- Elastic merges that include former independents. A design that kept the old gang as a precondition would never rebuild the row.
- A gang member whose only PC partner is invalid. A design that ignored valid would keep it ganged with a dead slice.
- Miss bits that differ inside a PC group, with the split both enabled and disabled. A wrong gate would split when it should not, or not split when it should.
- Strobe-free cycles with changing PCs. A design without the strobe gate would regroup on them, or leave fetch requests raised.

// File: rtl/sg_pkg.sv
// Package: shared types for the slice ganging controller.
// Assumes nothing beyond IEEE 1800-2017 synthesizable subset.
package sg_pkg;

    // Regrouping policy selected by the mode input.
    typedef enum logic {
        SG_INELASTIC = 1'b0,
        SG_ELASTIC   = 1'b1
    } sg_mode_e;

endpackage

// File: rtl/sg_pair_match.sv
// Module: sg_pair_match
// Builds the symmetric slice-to-slice match matrix: two slices match when
// both are valid, their PCs are equal and, if the memory split is enabled,
// their miss bits are equal too. Assumes the diagonal is never used.
module sg_pair_match #(
    parameter int NUM_SLICES = 8,
    parameter int PC_W       = 32
) (
    input  logic [NUM_SLICES*PC_W-1:0] pc_i,
    input  logic [NUM_SLICES-1:0]      vld_i,
    input  logic [NUM_SLICES-1:0]      miss_i,
    input  logic                       mem_split_en_i,
    output logic [NUM_SLICES-1:0]      match_o [NUM_SLICES]
);

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_row
        for (genvar j = 0; j < NUM_SLICES; j++) begin : g_col
            if (i == j) begin : g_diag
                // Purpose: a slice is not its own partner.
                assign match_o[i][j] = 1'b0;
            end else if (j > i) begin : g_upper
                logic pc_eq;
                logic miss_ok;
                // Purpose: one comparator per unordered slice pair.
                assign pc_eq   = pc_i[i*PC_W +: PC_W] == pc_i[j*PC_W +: PC_W];
                assign miss_ok = !mem_split_en_i || (miss_i[i] == miss_i[j]);
                assign match_o[i][j] = vld_i[i] && vld_i[j] && pc_eq && miss_ok;
            end else begin : g_lower
                // Purpose: mirror the upper triangle.
                assign match_o[i][j] = g_row[j].g_col[i].g_upper.pc_eq
                                       && vld_i[i] && vld_i[j]
                                       && g_row[j].g_col[i].g_upper.miss_ok;
            end
        end
    end

endmodule

// File: rtl/sg_regroup.sv
// Module: sg_regroup
// Combinational regrouping: from the match matrix and the current grouping
// it works out each slice's next gang ID (lowest member index), next ganged
// flag and whether it leads a gang of two or more. Assumes the match matrix
// is an equivalence over valid slices and the current gang IDs name the
// lowest member, so the join relation is itself an equivalence.
module sg_regroup #(
    parameter int NUM_SLICES = 8,
    localparam int ID_W      = $clog2(NUM_SLICES)
) (
    input  logic [NUM_SLICES-1:0] match_i [NUM_SLICES],
    input  logic [ID_W-1:0]       cur_id_i [NUM_SLICES],
    input  logic [NUM_SLICES-1:0] cur_ganged_i,
    input  sg_pkg::sg_mode_e      mode_i,
    output logic [ID_W-1:0]       nxt_id_o [NUM_SLICES],
    output logic [NUM_SLICES-1:0] nxt_ganged_o,
    output logic [NUM_SLICES-1:0] leader_o
);

    logic [NUM_SLICES-1:0] may_join [NUM_SLICES];

    // Purpose: decide which pairs may share a gang under the current policy.
    always_comb begin
        for (int i = 0; i < NUM_SLICES; i++) begin
            for (int j = 0; j < NUM_SLICES; j++) begin
                if (mode_i == sg_pkg::SG_ELASTIC) begin
                    may_join[i][j] = match_i[i][j];
                end else begin
                    may_join[i][j] = match_i[i][j] && cur_ganged_i[i]
                                     && cur_ganged_i[j]
                                     && (cur_id_i[i] == cur_id_i[j]);
                end
            end
        end
    end

    // Purpose: pick the lowest member index and the ganged flag per slice.
    always_comb begin
        for (int i = 0; i < NUM_SLICES; i++) begin
            nxt_id_o[i] = ID_W'(i);
            for (int j = NUM_SLICES - 1; j >= 0; j--) begin
                if (may_join[i][j] && (j < i)) begin
                    nxt_id_o[i] = ID_W'(j);
                end
            end
            nxt_ganged_o[i] = |may_join[i];
            leader_o[i]     = nxt_ganged_o[i] && (nxt_id_o[i] == ID_W'(i));
        end
    end

endmodule

// File: rtl/sg_gang_ctrl.sv
// Module: sg_gang_ctrl (top)
// Slice ganging controller. Holds the gang ID and ganged flag of every
// slice, regroups them on the PC-update strobe and pulses one fetch request
// per multi-slice gang on the following cycle. Assumes NUM_SLICES >= 2 and
// that the strobe inputs are stable around the rising clock edge.
module sg_gang_ctrl #(
    parameter int NUM_SLICES = 8,
    parameter int PC_W       = 32,
    localparam int ID_W      = $clog2(NUM_SLICES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       pc_upd_i,
    input  logic [NUM_SLICES*PC_W-1:0] slice_pc_i,
    input  logic [NUM_SLICES-1:0]      slice_vld_i,
    input  logic [NUM_SLICES-1:0]      slice_miss_i,
    input  logic                       elastic_mode_i,
    input  logic                       mem_split_en_i,
    output logic [NUM_SLICES*ID_W-1:0] gang_id_o,
    output logic [NUM_SLICES-1:0]      ganged_o,
    output logic [NUM_SLICES-1:0]      fetch_req_o
);

    logic [NUM_SLICES-1:0] match [NUM_SLICES];
    logic [ID_W-1:0]       id_q [NUM_SLICES];
    logic [ID_W-1:0]       id_d [NUM_SLICES];
    logic [NUM_SLICES-1:0] ganged_q;
    logic [NUM_SLICES-1:0] ganged_d;
    logic [NUM_SLICES-1:0] leader_d;
    logic [NUM_SLICES-1:0] fetch_q;
    sg_pkg::sg_mode_e      mode;

    // Purpose: map the mode pin onto the policy type.
    assign mode = sg_pkg::sg_mode_e'(elastic_mode_i);

    sg_pair_match #(.NUM_SLICES(NUM_SLICES), .PC_W(PC_W)) u_match (
        .pc_i           (slice_pc_i),
        .vld_i          (slice_vld_i),
        .miss_i         (slice_miss_i),
        .mem_split_en_i (mem_split_en_i),
        .match_o        (match)
    );

    sg_regroup #(.NUM_SLICES(NUM_SLICES)) u_regroup (
        .match_i      (match),
        .cur_id_i     (id_q),
        .cur_ganged_i (ganged_q),
        .mode_i       (mode),
        .nxt_id_o     (id_d),
        .nxt_ganged_o (ganged_d),
        .leader_o     (leader_d)
    );

    // Purpose: grouping state; all slices in gang 0 after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLICES; i++) id_q[i] <= '0;
            ganged_q <= '1;
            fetch_q  <= '0;
        end else if (pc_upd_i) begin
            for (int i = 0; i < NUM_SLICES; i++) id_q[i] <= id_d[i];
            ganged_q <= ganged_d;
            fetch_q  <= leader_d;
        end else begin
            fetch_q  <= '0;
        end
    end

    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_out
        // Purpose: flatten the per-slice gang IDs onto the port.
        assign gang_id_o[i*ID_W +: ID_W] = id_q[i];
    end
    assign ganged_o    = ganged_q;
    assign fetch_req_o = fetch_q;

    // Per-slice checks on the held grouping state.
    for (genvar i = 0; i < NUM_SLICES; i++) begin : g_chk
        assert_indep_self_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !ganged_q[i] |-> id_q[i] == ID_W'(i));
        assert_leader_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ganged_q[i] |-> ganged_q[id_q[i]] && (id_q[id_q[i]] == id_q[i]));
        assert_hold_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !pc_upd_i |=> $stable(id_q[i]) && $stable(ganged_q[i]));
        assert_indep_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!elastic_mode_i && !ganged_q[i]) |=> !ganged_q[i]);
        assert_fetch_leader_R8: assert property (@(posedge clk) disable iff (!rst_n)
            fetch_q[i] |-> ganged_q[i] && (id_q[i] == ID_W'(i)));
        for (genvar j = i + 1; j < NUM_SLICES; j++) begin : g_pair
            assert_gang_same_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(pc_upd_i) && ganged_q[i] && ganged_q[j]
                 && (id_q[i] == id_q[j]))
                |-> $past(slice_pc_i[i*PC_W +: PC_W] == slice_pc_i[j*PC_W +: PC_W]));
            assert_gang_same_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(pc_upd_i && mem_split_en_i) && ganged_q[i]
                 && ganged_q[j] && (id_q[i] == id_q[j]))
                |-> $past(slice_miss_i[i] == slice_miss_i[j]));
        end
    end

endmodule

// File: tb/tb_sg_gang_ctrl.sv
// Bench for sg_gang_ctrl: behavioural reference model stepped on each
// rising edge and compared with the outputs at every falling edge.
module tb_sg_gang_ctrl;
    localparam int N    = 8;
    localparam int PW   = 32;
    localparam int IW   = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd = 1'b0;
    logic [PW-1:0] pcs [N];
    logic [N*PW-1:0] pc_flat;
    logic [N-1:0] vld = '1;
    logic [N-1:0] miss = '0;
    logic el = 1'b0;
    logic men = 1'b0;
    logic [N*IW-1:0] gid;
    logic [N-1:0] gflag;
    logic [N-1:0] freq;

    int m_id [N];
    bit m_g [N];
    bit m_f [N];
    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    always_comb for (int i = 0; i < N; i++) pc_flat[i*PW +: PW] = pcs[i];

    sg_gang_ctrl #(.NUM_SLICES(N), .PC_W(PW)) dut (
        .clk(clk), .rst_n(rst_n), .pc_upd_i(upd), .slice_pc_i(pc_flat),
        .slice_vld_i(vld), .slice_miss_i(miss), .elastic_mode_i(el),
        .mem_split_en_i(men), .gang_id_o(gid), .ganged_o(gflag),
        .fetch_req_o(freq)
    );

    // Reference: apply the requirement rules to the model state.
    task automatic model_step();
        int nid [N];
        bit ng [N];
        bit joins;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_id[i] = 0; m_g[i] = 1; m_f[i] = 0; end
        end else if (!upd) begin
            for (int i = 0; i < N; i++) m_f[i] = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                nid[i] = i; ng[i] = 0;
                for (int j = N - 1; j >= 0; j--) begin
                    joins = (i != j) && vld[i] && vld[j] && pcs[i] == pcs[j]
                            && (!men || miss[i] == miss[j])
                            && (el || (m_g[i] && m_g[j] && m_id[i] == m_id[j]));
                    if (joins) begin
                        ng[i] = 1;
                        if (j < i) nid[i] = j;
                    end
                end
            end
            for (int i = 0; i < N; i++) begin
                m_id[i] = nid[i]; m_g[i] = ng[i]; m_f[i] = ng[i] && nid[i] == i;
            end
        end
    endtask

    task automatic compare(string tag);
        for (int i = 0; i < N; i++) begin
            checks++;
            if (int'(gid[i*IW +: IW]) != m_id[i] || gflag[i] != m_g[i]) begin
                errors++;
                $display("FAIL %s slice %0d: id=%0d ganged=%0b expected id=%0d ganged=%0b",
                         tag, i, gid[i*IW +: IW], gflag[i], m_id[i], m_g[i]);
            end
            checks++;
            if (freq[i] != m_f[i]) begin
                errors++;
                $display("FAIL %s R8 fetch[%0d]=%0b expected %0b", tag, i, freq[i], m_f[i]);
            end
        end
    endtask

    task automatic cyc(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        upd = 1'b0;
        compare(tag);
    endtask

    task automatic set_pcs(input int p0, p1, p2, p3, p4, p5, p6, p7);
        pcs[0] = PW'(p0); pcs[1] = PW'(p1); pcs[2] = PW'(p2); pcs[3] = PW'(p3);
        pcs[4] = PW'(p4); pcs[5] = PW'(p5); pcs[6] = PW'(p6); pcs[7] = PW'(p7);
    endtask

    task automatic strobe(string tag);
        upd = 1'b1;
        cyc(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc("R1 in reset");
        cyc("R1 in reset");
        rst_n = 1'b1;
        cyc("R1 after reset");
    endtask

    initial begin
        set_pcs(0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        do_reset();
        // R1 stated directly
        checks++;
        if (gid != '0 || gflag != '1 || freq != '0) begin
            errors++;
            $display("FAIL R1 reset state id=%h ganged=%b fetch=%b expected 0/ff/00", gid, gflag, freq);
        end
        // R3/R8: converged strobe keeps one gang
        set_pcs('h40, 'h40, 'h40, 'h40, 'h40, 'h40, 'h40, 'h40);
        strobe("R3 converged");
        cyc("R2 fetch drop");
        // R2: divergent PCs without strobe are ignored
        set_pcs(1, 2, 3, 4, 5, 6, 7, 8);
        cyc("R2 no strobe");
        cyc("R2 no strobe");
        // R3/R4: split into gangs and independents
        set_pcs('hA, 'hA, 'hB, 'hB, 'hC, 'hA, 'hD, 'hB);
        strobe("R3 R4 split");
        // R5: inelastic, all equal PCs, no merging
        set_pcs('h80, 'h80, 'h80, 'h80, 'h80, 'h80, 'h80, 'h80);
        strobe("R5 no merge");
        // R7: miss split inside gang 0
        men = 1'b1; miss = 8'b0000_0010;
        strobe("R7 split on miss");
        men = 1'b0;
        // R4: invalid partner leaves slice alone
        vld = 8'b1111_0111;
        strobe("R4 invalid slice");
        vld = '1;
        // R6: elastic merge of everything
        el = 1'b1;
        strobe("R6 elastic merge");
        set_pcs(1, 2, 1, 2, 1, 2, 1, 2);
        strobe("R6 elastic pattern");
        set_pcs(5, 5, 5, 5, 5, 5, 5, 5);
        strobe("R6 remerge");
        // R7: miss ignored when disabled
        miss = 8'b1010_0110;
        strobe("R7 miss ignored");
        men = 1'b1;
        strobe("R7 miss split elastic");
        // Mixed random traffic
        el = 1'b0; men = 1'b0; miss = '0;
        do_reset();
        for (int k = 0; k < 1500; k++) begin
            for (int i = 0; i < N; i++) pcs[i] = PW'('h100 + 4 * ($urandom % 3));
            vld  = N'($urandom) | N'($urandom);
            miss = N'($urandom);
            if (k % 40 == 0) el = 1'($urandom);
            if (k % 25 == 0) men = 1'($urandom);
            upd = 1'($urandom);
            if (k % 300 == 299) do_reset();
            else cyc("R3 R5 R6 random");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule